// File: doc/BRIEF.md
# Serial Audio Codec Port

This block is a full-duplex serial port to an external 8-bit audio codec. From a reference clock it divides down a single bit clock that both directions share. With each frame it emits a one-bit-period frame sync, shifts one byte out of a transmit FIFO onto the serial output, and assembles one byte from the serial input into a receive FIFO. The parallel side is register-style: one write strobe loads a byte into the transmit FIFO and one read strobe removes the oldest received byte.

A frame is nine bit-clock periods. The first period carries the frame sync and a zero on the data line. The eight data bits follow, most significant bit first. Outgoing bits change on the rising edge of the bit clock and incoming bits are sampled on its falling edge, so the codec has half a bit period of setup on each side. Software sets the divider while the port is disabled and then raises the enable. Frames then follow back to back until the enable drops.

Top module: `codec_serial_port`

## Requirements
- R1: With divider value N the bit clock has a period of 2×(N+1) reference cycles, and its first rising edge comes N+1 cycles after enable rises. While disabled the bit clock is held low.
- R2: The divider value is captured only while the port is disabled. A change on the divider input while enabled does not alter the bit-clock period.
- R3: Each frame has 9 bit periods. Frame sync is high for exactly the first of them, rising together with the bit clock, and the 8 data bits that follow are sent most significant bit first.
- R4: The serial output changes only on the reference cycle in which the bit clock rises. During the sync period it is 0.
- R5: The serial input is sampled on each falling bit-clock edge of data periods 1..8. The first sample becomes bit 7 of the received byte, and the byte is pushed at the eighth sample.
- R6: The transmit FIFO holds 16 bytes and sends them in write order. tx_full is set at 16 entries, a write while full is ignored, and tx_empty is set at 0 entries.
- R7: The receive FIFO holds 16 bytes. rd_data shows the oldest byte, a read strobe removes it, and rx_full and rx_empty reflect 16 and 0 entries.
- R8: If the transmit FIFO is empty at a frame start, that frame sends 8 zero bits and tx_underrun is set and held.
- R9: A received byte that completes while the receive FIFO is full is dropped, the stored bytes are kept, and rx_overrun is set and held.
- R10: After reset, or one cycle after enable is low, fsync_o, sdo_o, bclk_o, tx_underrun and rx_overrun are 0. FIFO contents survive a disable.
- R11: Transmit and receive run in the same frames. A byte sent and a byte received in one frame both complete within that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Port enable; low stops framing and allows the divider to load |
| div_val | input | 8 | Divider value N |
| wr_en | input | 1 | Write strobe into the transmit FIFO |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe on the receive FIFO |
| rd_data | output | 8 | Oldest received byte |
| sdi | input | 1 | Serial data from the codec |
| bclk_o | output | 1 | Bit clock to the codec |
| fsync_o | output | 1 | Frame sync |
| sdo_o | output | 1 | Serial data to the codec |
| tx_full | output | 1 | Transmit FIFO holds 16 bytes |
| tx_empty | output | 1 | Transmit FIFO is empty |
| rx_full | output | 1 | Receive FIFO holds 16 bytes |
| rx_empty | output | 1 | Receive FIFO is empty |
| tx_underrun | output | 1 | Sticky: a frame started with no byte to send |
| rx_overrun | output | 1 | Sticky: a received byte was dropped |

## Verification
The bench builds the port with its default parameters: 8-bit words, 16-entry FIFOs and an 8-bit divider. With these it can fill both FIFOs to their limit and push one byte past it in a few hundred cycles. Divider values 0 to 5 cover the shortest possible bit clock, where the falling-edge sample lands on the very next reference cycle after the bench drives the data, as well as longer ones where the two half periods can be counted separately. A bench-side serial model drives the input and decodes the output from the pins alone, so bit order, the sync position and duplex timing are judged without looking inside the block.

// File: rtl/codec_pkg.sv
package codec_pkg;
  localparam int WORD_W = 8;

  // Reference cycles in one full bit-clock period for divider value div.
  function automatic int unsigned bclk_period(input int unsigned div);
    return 2 * (div + 1);
  endfunction

  // Bit periods in one frame: one sync period plus one per data bit.
  function automatic int unsigned frame_slots(input int unsigned width);
    return width + 1;
  endfunction
endpackage

// File: rtl/codec_bitclk_gen.sv
module codec_bitclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_in,
  output logic             bclk,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic [DIV_W-1:0] div_active
);
  logic [DIV_W-1:0] cnt;
  logic             half_done;

  assign half_done = en && (cnt == div_active);
  assign rise_evt  = half_done && !bclk;
  assign fall_evt  = half_done && bclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_active <= '0;
      cnt        <= '0;
      bclk       <= 1'b0;
    end else if (!en) begin
      div_active <= div_in;
      cnt        <= '0;
      bclk       <= 1'b0;
    end else if (half_done) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/codec_byte_fifo.sv
module codec_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [W-1:0]       wdata,
  input  logic               rd,
  output logic [W-1:0]       rdata,
  output logic               full,
  output logic               empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW   = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL_LV = LW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_wr, do_rd;

  assign full  = (level == FULL_LV);
  assign empty = (level == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= (wp == LAST_IX) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == LAST_IX) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/codec_frame_engine.sv
module codec_frame_engine
  import codec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              sdi,
  output logic              tx_pop,
  output logic              underrun_evt,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_byte,
  output logic              fsync,
  output logic              sdo
);
  localparam int SLOTS  = frame_slots(DATA_W);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic              active;
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              frame_start;

  assign frame_start  = rise_evt && (!active || slot == LAST);
  assign tx_pop       = frame_start && !tx_empty;
  assign underrun_evt = frame_start && tx_empty;
  assign rx_push      = fall_evt && active && (slot == LAST);
  assign rx_byte      = {rx_sh[DATA_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      active <= 1'b0;
      slot   <= '0;
      fsync  <= 1'b0;
      sdo    <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      if (frame_start) begin
        active <= 1'b1;
        slot   <= '0;
        fsync  <= 1'b1;
        sdo    <= 1'b0;
        tx_sh  <= tx_empty ? '0 : tx_data;
      end else if (rise_evt) begin
        slot  <= slot + 1'b1;
        fsync <= 1'b0;
        sdo   <= tx_sh[DATA_W-1];
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
      if (fall_evt && active && slot != '0)
        rx_sh <= rx_byte;
    end
  end
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import codec_pkg::*;
#(
  parameter int DATA_W     = WORD_W,
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sdi,
  output logic              bclk_o,
  output logic              fsync_o,
  output logic              sdo_o,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              tx_underrun,
  output logic              rx_overrun
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic              rise_evt, fall_evt;
  logic [DIV_W-1:0]  div_active;
  logic              tx_pop, underrun_evt, rx_push;
  logic [DATA_W-1:0] tx_head, rx_byte;
  logic [LW-1:0]     tx_level, rx_level;
  logic              overrun_evt;

  codec_bitclk_gen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(en), .div_in(div_val),
    .bclk(bclk_o), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .div_active(div_active)
  );

  codec_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .wr(wr_en), .wdata(wr_data),
    .rd(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty),
    .level(tx_level)
  );

  codec_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .wr(rx_push), .wdata(rx_byte),
    .rd(rd_en), .rdata(rd_data), .full(rx_full), .empty(rx_empty),
    .level(rx_level)
  );

  codec_frame_engine #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(en),
    .rise_evt(rise_evt), .fall_evt(fall_evt),
    .tx_empty(tx_empty), .tx_data(tx_head), .sdi(sdi),
    .tx_pop(tx_pop), .underrun_evt(underrun_evt),
    .rx_push(rx_push), .rx_byte(rx_byte),
    .fsync(fsync_o), .sdo(sdo_o)
  );

  assign overrun_evt = rx_push && rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      tx_underrun <= 1'b0;
      rx_overrun  <= 1'b0;
    end else begin
      if (underrun_evt) tx_underrun <= 1'b1;
      if (overrun_evt)  rx_overrun  <= 1'b1;
    end
  end
endmodule

// File: rtl/codec_serial_port_chk.sv
module codec_serial_port_chk
  import codec_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  parameter int LW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             bclk_o,
  input logic             fsync_o,
  input logic             sdo_o,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             rx_push,
  input logic             rx_full,
  input logic             tx_underrun,
  input logic             rx_overrun,
  input logic [DIV_W-1:0] div_active,
  input logic [LW-1:0]    tx_level,
  input logic [LW-1:0]    rx_level
);
  int unsigned gap;
  logic        seen_rise;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      gap       <= 0;
      seen_rise <= 1'b0;
    end else if (rise_evt) begin
      gap       <= 1;
      seen_rise <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && seen_rise) |-> (gap == bclk_period(int'(div_active))));

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bclk_o);

  p_div_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(div_active));

  p_sync_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_o) |-> $rose(bclk_o));

  p_sync_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && fsync_o) |=> !fsync_o);

  p_sdo_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(sdo_o)) |-> $rose(bclk_o));

  p_sample_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (fall_evt && bclk_o));

  p_tx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH));

  p_rx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH));

  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_push && rx_full) |=> rx_overrun);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tx_underrun && !rx_overrun && !fsync_o && !sdo_o));
endmodule

bind codec_serial_port codec_serial_port_chk #(
  .DEPTH(FIFO_DEPTH), .DIV_W(DIV_W), .LW($clog2(FIFO_DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bclk_o(bclk_o), .fsync_o(fsync_o),
  .sdo_o(sdo_o), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .rx_push(rx_push), .rx_full(rx_full), .tx_underrun(tx_underrun),
  .rx_overrun(rx_overrun), .div_active(div_active),
  .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/codec_serial_port_test.sv
`timescale 1ns/1ps
module codec_serial_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] div_val = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       sdi = 1'b0;
  logic       bclk_o, fsync_o, sdo_o;
  logic       tx_full, tx_empty, rx_full, rx_empty, tx_underrun, rx_overrun;

  always #2.5 clk = ~clk;

  codec_serial_port uut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_val(div_val),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .sdi(sdi), .bclk_o(bclk_o), .fsync_o(fsync_o), .sdo_o(sdo_o),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full),
    .rx_empty(rx_empty), .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pin-level serial model: decodes sdo, drives sdi, measures the period.
  logic [7:0] cap_q [32];
  int         cap_n = 0;
  int         cap_idx = 8;
  logic [7:0] cap_sh;
  int         drv_idx = 8;
  logic [7:0] drv_byte;
  logic [7:0] rx_base = '0;
  int         frm_no = 0;
  int         cyc = 0;
  int         last_rise = 0;
  int         last_period = 0;
  logic       prev_b = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (bclk_o && !prev_b) begin
      last_period = cyc - last_rise;
      last_rise   = cyc;
      if (fsync_o) begin
        cap_idx  = 0;
        drv_idx  = 0;
        drv_byte = rx_base + 8'(frm_no);
        frm_no++;
        sdi = 1'b0;
      end else begin
        if (cap_idx < 8) begin
          cap_sh = {cap_sh[6:0], sdo_o};
          cap_idx++;
          if (cap_idx == 8 && cap_n < 32) begin
            cap_q[cap_n] = cap_sh;
            cap_n++;
          end
        end
        if (drv_idx < 8) begin
          sdi = drv_byte[7 - drv_idx];
          drv_idx++;
        end
      end
    end
    prev_b = bclk_o;
  end

  task automatic push_tx(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_rx();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic model_clear(input logic [7:0] base);
    rx_base = base; frm_no = 0; cap_n = 0; cap_idx = 8; drv_idx = 8;
  endtask

  // {divider, byte sent, byte the codec returns}
  localparam logic [23:0] VECS [4] = '{
    24'h00A53C, 24'h01817E, 24'h030180, 24'h02FF00
  };

  initial begin
    #750000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10: reset state
    chk("R10 bclk reset", bclk_o, 0);
    chk("R10 fsync/sdo reset", {fsync_o, sdo_o}, 0);
    chk("R10 flags reset", {tx_underrun, rx_overrun}, 0);
    chk("R6 R7 empty after reset", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);

    // Table-driven: one frame each way per divider setting (R1 R3 R5 R11)
    foreach (VECS[v]) begin
      logic [7:0] d, t, r;
      int w;
      {d, t, r} = VECS[v];
      en = 1'b0; div_val = d;
      idle(2);
      model_clear(r);
      push_tx(t);
      en = 1'b1;
      w = 0;
      while (rx_empty && w < 1000) begin @(negedge clk); w++; end
      chk("R3 byte sent MSB first", (cap_n > 0) ? int'(cap_q[0]) : -1, int'(t));
      chk("R5 R11 byte received in same frame", rd_data, r);
      chk("R1 bit clock period", last_period, 2 * (int'(d) + 1));
      chk("R8 no underrun with data", tx_underrun, 0);
      en = 1'b0;
      pop_rx();
    end

    // Fill both FIFOs past the limit (R6 R7 R8 R9)
    en = 1'b0; div_val = 8'd0;
    idle(2);
    model_clear(8'h40);
    for (int i = 0; i < 16; i++) push_tx(8'(i * 7 + 3));
    chk("R6 tx_full at 16", tx_full, 1);
    push_tx(8'hEE);
    en = 1'b1;
    begin
      int w = 0;
      while (!rx_overrun && w < 3000) begin @(negedge clk); w++; end
    end
    chk("R9 overrun flag", rx_overrun, 1);
    chk("R8 underrun flag", tx_underrun, 1);
    chk("R7 rx_full", rx_full, 1);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) if (cap_q[i] !== 8'(i * 7 + 3)) bad++;
      chk("R6 tx order kept", bad, 0);
    end
    chk("R6 R8 write-while-full ignored, zeros sent", cap_q[16], 0);
    en = 1'b0;
    idle(1);
    chk("R10 flags cleared when disabled", {tx_underrun, rx_overrun}, 0);
    chk("R1 bit clock low when disabled", bclk_o, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) begin
        if (rd_data !== 8'(8'h40 + i)) bad++;
        pop_rx();
      end
      chk("R7 R9 oldest 16 kept in order", bad, 0);
    end
    chk("R7 rx_empty after draining", rx_empty, 1);

    // Divider frozen while enabled (R2), underrun with empty queue (R8)
    model_clear(8'h00);
    div_val = 8'd0;
    idle(2);
    en = 1'b1;
    idle(1);
    div_val = 8'd5;
    idle(100);
    chk("R2 period unchanged while enabled", last_period, 2);
    chk("R8 underrun sends zeros", (cap_n > 0) ? int'(cap_q[0]) : -1, 0);
    chk("R8 underrun flag on empty queue", tx_underrun, 1);
    en = 1'b0;
    idle(2);
    en = 1'b1;
    idle(200);
    chk("R2 new divider after disable", last_period, 12);
    en = 1'b0;
    idle(4);
    while (!rx_empty) pop_rx();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule